// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block is a purely combinational 64-bit adder and subtractor. Its carry chain can be cut into independent lanes, so one pass works on packed vectors. The lanes can be eight 8-bit values, four 16-bit values, two 32-bit values or a single 64-bit value. One select chooses addition or subtraction for every lane. A second select chooses whether the operands are read as two's-complement signed numbers or as unsigned numbers.

Every lane detects its own overflow and reports it on a per-lane flag. When the saturate enable is high, an overflowing lane returns the extreme value of its format. When the saturate enable is low, the lane returns the ordinary wraparound result and the flag is still set. The block is meant to sit in the execute stage of a media datapath. It is driven from operand registers, and its outputs are captured by the next pipeline register.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_sel` picks the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 gives 32-bit lanes and 3 gives one 64-bit lane. No carry crosses a lane boundary. For example, in 8-bit mode 0xFF+0x01 in byte 0 gives 0x00 and leaves byte 1 unchanged.
- R2: With `sub_en`=1, every lane computes op_a minus op_b as op_a plus the bitwise inverse of op_b plus one. With `sub_en`=0, every lane adds.
- R3: For a signed add (`signed_en`=1, `sub_en`=0), a lane overflows exactly when both operands have the same sign and the lane result has the other sign. Operands of opposite sign never overflow.
- R4: For a signed subtract, a lane overflows when a negative value minus a positive one gives a non-negative result, or when a non-negative value minus a negative one gives a negative result. Operands of the same sign never overflow.
- R5: For unsigned operation (`signed_en`=0), an add overflows when the lane produces a carry-out. A subtract overflows when the lane produces no carry-out, that is, when op_a < op_b.
- R6: With `sat_en`=0, every lane returns its result modulo 2^w, and its overflow flag is still reported.
- R7: With `sat_en`=1 and signed operation, a lane with positive overflow returns the largest positive value (0x7F.., top bit 0, the rest 1). A lane with negative overflow returns the most negative value (0x80.., top bit 1, the rest 0).
- R8: With `sat_en`=1 and unsigned operation, a lane that overflows on an add returns all ones. A lane that underflows on a subtract returns zero.
- R9: `ovf[i]` carries the flag of the lane whose most significant byte is byte i (bits 8i+7..8i). All other bits of `ovf` are 0. In 64-bit mode the single flag appears on `ovf[7]`.
- R10: The result and flag of each lane depend only on that lane's own operand bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand (the subtrahend when subtracting) |
| lane_sel | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| signed_en | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| sat_en | input | 1 | 1 = clamp overflowing lanes, 0 = wraparound |
| result | output | 64 | Packed lane results |
| ovf | output | 8 | Per-lane overflow flags, placed at each lane's top byte |

## Verification
The hardest situation to reach is a word in which lanes next to each other overflow in different directions, or in which one lane overflows while its neighbour sits exactly at its limit. A carry leaking across a boundary, or a clamp value taken from the wrong lane, only shows up then. Random operands rarely produce it. The stimulus therefore builds each byte from a small set of edge values (0x00, 0x01, 0x7F, 0x80, 0xFE, 0xFF) mixed with random bytes. It sweeps all four lane widths with every combination of add/subtract, signed/unsigned and saturation. A behavioural model works out each lane as a wide integer and compares its answer against the outputs every clock.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

  typedef enum logic [1:0] {
    MODE_B8  = 2'd0,
    MODE_B16 = 2'd1,
    MODE_B32 = 2'd2,
    MODE_B64 = 2'd3
  } lane_mode_e;

  // number of slices per lane minus one, for a lane-size code
  function automatic int unsigned lane_span_mask(input int unsigned mode);
    return (32'd1 << mode) - 32'd1;
  endfunction

  // two's-complement overflow from the sign bits seen by the adder
  function automatic logic signed_overflow(input logic a_msb, input logic b_eff_msb,
                                           input logic sum_msb);
    return (a_msb == b_eff_msb) && (sum_msb != a_msb);
  endfunction

  // unsigned overflow: carry-out on add, missing carry-out on subtract
  function automatic logic unsigned_overflow(input logic carry_out, input logic is_sub);
    return is_sub ? ~carry_out : carry_out;
  endfunction

  // direction of the clamp: 1 = towards the top of the range
  function automatic logic clamp_upward(input logic is_signed, input logic a_msb,
                                        input logic is_sub);
    return is_signed ? ~a_msb : ~is_sub;
  endfunction

endpackage

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  input  logic               invert_b,
  output logic [SLICE_W-1:0] sum,
  output logic               cout,
  output logic               a_msb,
  output logic               b_eff_msb
);
  logic [SLICE_W-1:0] b_eff;

  assign b_eff = invert_b ? ~b : b;
  assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{SLICE_W{1'b0}}, cin};
  assign a_msb = a[SLICE_W-1];
  assign b_eff_msb = b_eff[SLICE_W-1];
endmodule

// File: rtl/simd_lane_judge.sv
module simd_lane_judge
  import simd_sat_pkg::*;
(
  input  logic a_msb,
  input  logic b_eff_msb,
  input  logic sum_msb,
  input  logic carry_out,
  input  logic is_sub,
  input  logic is_signed,
  output logic overflow,
  output logic clamp_up
);
  assign overflow = is_signed ? signed_overflow(a_msb, b_eff_msb, sum_msb)
                              : unsigned_overflow(carry_out, is_sub);
  assign clamp_up = clamp_upward(is_signed, a_msb, is_sub);
endmodule

// File: rtl/simd_slice_sat.sv
module simd_slice_sat #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] sum,
  input  logic               lane_ovf,
  input  logic               clamp_up,
  input  logic               sat_en,
  input  logic               is_signed,
  input  logic               is_lane_top,
  output logic [SLICE_W-1:0] out
);
  logic [SLICE_W-1:0] clamp_val;

  always_comb begin
    clamp_val = {SLICE_W{clamp_up}};
    if (is_signed && is_lane_top) clamp_val[SLICE_W-1] = ~clamp_up;
  end

  assign out = (sat_en && lane_ovf) ? clamp_val : sum;
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_sat_pkg::*;
#(
  parameter  int DATA_W  = 64,
  parameter  int SLICE_W = 8,
  localparam int NSLICE  = DATA_W / SLICE_W,
  localparam int SIDX_W  = $clog2(NSLICE),
  localparam int MODE_W  = $clog2(SIDX_W + 1)
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [MODE_W-1:0] lane_sel,
  input  logic              sub_en,
  input  logic              signed_en,
  input  logic              sat_en,
  output logic [DATA_W-1:0] result,
  output logic [NSLICE-1:0] ovf
);
  // span_mask: low index bits shared by all slices of one lane
  logic [SIDX_W-1:0] span_mask;
  assign span_mask = SIDX_W'(lane_span_mask(32'(lane_sel)));

  // named slice-level events, visible to the checker
  logic [NSLICE-1:0] carry_in;
  logic [NSLICE-1:0] carry_out;
  logic [NSLICE-1:0] lane_top;
  logic [NSLICE-1:0] lane_base;
  logic [NSLICE-1:0] judge_ovf;
  logic [NSLICE-1:0] judge_up;
  logic [NSLICE-1:0] a_msb;
  logic [NSLICE-1:0] b_eff_msb;
  logic [SLICE_W-1:0] slice_sum [NSLICE];

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam logic [SIDX_W-1:0] IDX = SIDX_W'(i);

    assign lane_base[i] = ((IDX & span_mask) == '0);
    assign lane_top[i]  = ((IDX & span_mask) == span_mask);

    // carry chain cut: a lane's lowest slice takes the negation +1
    if (i == 0) begin : g_first
      assign carry_in[i] = sub_en;
    end else begin : g_rest
      assign carry_in[i] = lane_base[i] ? sub_en : carry_out[i-1];
    end

    simd_slice_add #(.SLICE_W(SLICE_W)) u_add (
      .a        (op_a[i*SLICE_W +: SLICE_W]),
      .b        (op_b[i*SLICE_W +: SLICE_W]),
      .cin      (carry_in[i]),
      .invert_b (sub_en),
      .sum      (slice_sum[i]),
      .cout     (carry_out[i]),
      .a_msb    (a_msb[i]),
      .b_eff_msb(b_eff_msb[i])
    );

    simd_lane_judge u_judge (
      .a_msb    (a_msb[i]),
      .b_eff_msb(b_eff_msb[i]),
      .sum_msb  (slice_sum[i][SLICE_W-1]),
      .carry_out(carry_out[i]),
      .is_sub   (sub_en),
      .is_signed(signed_en),
      .overflow (judge_ovf[i]),
      .clamp_up (judge_up[i])
    );

    // every slice follows the verdict of its lane's top slice
    logic [SIDX_W-1:0] owner;
    logic              own_ovf;
    logic              own_up;
    always_comb begin
      owner   = IDX | span_mask;
      own_ovf = judge_ovf[owner];
      own_up  = judge_up[owner];
    end

    simd_slice_sat #(.SLICE_W(SLICE_W)) u_sat (
      .sum        (slice_sum[i]),
      .lane_ovf   (own_ovf),
      .clamp_up   (own_up),
      .sat_en     (sat_en),
      .is_signed  (signed_en),
      .is_lane_top(lane_top[i]),
      .out        (result[i*SLICE_W +: SLICE_W])
    );
  end

  assign ovf = judge_ovf & lane_top;
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk
  import simd_sat_pkg::*;
#(
  parameter  int DATA_W  = 64,
  parameter  int SLICE_W = 8,
  localparam int NSLICE  = DATA_W / SLICE_W,
  localparam int SIDX_W  = $clog2(NSLICE),
  localparam int MODE_W  = $clog2(SIDX_W + 1)
) (
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [MODE_W-1:0] lane_sel,
  input logic              sub_en,
  input logic              signed_en,
  input logic              sat_en,
  input logic [DATA_W-1:0] result,
  input logic [NSLICE-1:0] ovf
);
  logic [NSLICE-1:0] allowed_flags;
  logic [SLICE_W-1:0] low_a, low_b, low_r;

  always_comb begin
    allowed_flags = '0;
    for (int i = 0; i < NSLICE; i++) begin
      if (((i + 1) % (1 << lane_sel)) == 0) allowed_flags[i] = 1'b1;
    end
    low_a = op_a[SLICE_W-1:0];
    low_b = op_b[SLICE_W-1:0];
    low_r = result[SLICE_W-1:0];
  end

  always_comb begin
    // R9
    flag_position_chk: assert ((ovf & ~allowed_flags) == '0);
    // R1
    byte_lane_isolated_chk: assert (!(lane_sel == MODE_B8 && !sat_en && !sub_en)
                                    || low_r == SLICE_W'(low_a + low_b));
    // R6
    full_wrap_chk: assert (!(lane_sel == MODE_B64 && !sat_en)
                           || result == (sub_en ? op_a - op_b : op_a + op_b));
    // R3
    mixed_sign_add_chk: assert (!(lane_sel == MODE_B64 && signed_en && !sub_en
                                  && op_a[DATA_W-1] != op_b[DATA_W-1]) || !ovf[NSLICE-1]);
    // R8
    unsigned_clamp_chk: assert (!(lane_sel == MODE_B64 && !signed_en && sat_en && ovf[NSLICE-1])
                                || result == (sub_en ? '0 : '1));
    // R7
    signed_clamp_chk: assert (!(lane_sel == MODE_B8 && signed_en && sat_en && ovf[0])
                              || low_r == {1'b0, {(SLICE_W-1){1'b1}}}
                              || low_r == {1'b1, {(SLICE_W-1){1'b0}}});
  end
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .lane_sel (lane_sel),
  .sub_en   (sub_en),
  .signed_en(signed_en),
  .sat_en   (sat_en),
  .result   (result),
  .ovf      (ovf)
);

// File: tb/simd_sat_adder_test.sv
`timescale 1ns/1ps
module simd_sat_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_sel = '0;
  logic        sub_en = 1'b0, signed_en = 1'b0, sat_en = 1'b0;
  logic [63:0] result;
  logic [7:0]  ovf;
  int          total = 0;
  int          bad = 0;
  bit          cmp_on = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  simd_sat_adder uut (
    .op_a(op_a), .op_b(op_b), .lane_sel(lane_sel), .sub_en(sub_en),
    .signed_en(signed_en), .sat_en(sat_en), .result(result), .ovf(ovf)
  );

  // behavioural model: each lane as a wide integer
  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] m, input logic sub, input logic sgn,
                                input logic sat, output logic [63:0] r, output logic [7:0] f);
    int w = 8 << m;
    r = '0;
    f = '0;
    for (int k = 0; k < 64 / w; k++) begin
      logic signed [67:0] av, bv, s, hi, lo, v;
      logic ov;
      av = '0;
      bv = '0;
      for (int j = 0; j < w; j++) begin
        av[j] = a[k*w+j];
        bv[j] = b[k*w+j];
      end
      if (sgn && av[w-1]) av = av - (68'sd1 <<< w);
      if (sgn && bv[w-1]) bv = bv - (68'sd1 <<< w);
      s = sub ? av - bv : av + bv;
      if (sgn) begin
        hi = (68'sd1 <<< (w - 1)) - 68'sd1;
        lo = -(68'sd1 <<< (w - 1));
      end else begin
        hi = (68'sd1 <<< w) - 68'sd1;
        lo = 68'sd0;
      end
      ov = (s > hi) || (s < lo);
      v = (ov && sat) ? ((s > hi) ? hi : lo) : s;
      for (int j = 0; j < w; j++) r[k*w+j] = v[j];
      f[k*(w/8) + w/8 - 1] = ov;
    end
  endfunction

  // reference comparison on every clock
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [63:0] er;
      logic [7:0]  ef;
      string tg;
      model(op_a, op_b, lane_sel, sub_en, signed_en, sat_en, er, ef);
      tg = sat_en ? (signed_en ? "R7" : "R8") : "R6";
      total++;
      if (result !== er || ovf !== ef) begin
        bad++;
        $display("FAIL %s model mode=%0d sub=%0b sgn=%0b sat=%0b a=%h b=%h actual=%h/%h expected=%h/%h",
                 tg, lane_sel, sub_en, signed_en, sat_en, op_a, op_b, result, ovf, er, ef);
      end
    end
  end

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                       input logic sub, input logic sgn, input logic sat);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; lane_sel = m; sub_en = sub; signed_en = sgn; sat_en = sat;
  endtask

  task automatic expect_out(input logic [63:0] er, input logic [7:0] ef, input string tag);
    @(negedge clk);
    total++;
    if (result !== er || ovf !== ef) begin
      bad++;
      $display("FAIL %s actual=%h/%h expected=%h/%h", tag, result, ovf, er, ef);
    end
  endtask

  function automatic logic [7:0] edge_byte();
    case ($urandom_range(0, 7))
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7F;
      3: return 8'h80;
      4: return 8'hFE;
      5: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    // reset state: idle inputs give a zero result, no flags
    expect_out(64'h0, 8'h00, "R1 reset");
    cmp_on = 1'b1;

    drive(64'h00000000_000000FF, 64'h1, 2'd0, 0, 0, 0);
    expect_out(64'h0, 8'h01, "R1 byte carry cut");
    drive(64'h00000000_000000FF, 64'h1, 2'd1, 0, 0, 0);
    expect_out(64'h100, 8'h00, "R1 halfword carry kept");
    drive(64'h00000005_00000007, 64'h00000003_00000002, 2'd2, 1, 0, 0);
    expect_out(64'h00000002_00000005, 8'h00, "R2 word subtract");
    drive(64'h7F, 64'h01, 2'd0, 0, 1, 0);
    expect_out(64'h80, 8'h01, "R3 signed add overflow");
    drive(64'h80, 64'h7F, 2'd0, 0, 1, 0);
    expect_out(64'hFF, 8'h00, "R3 mixed sign add");
    drive(64'h8000, 64'h0001, 2'd1, 1, 1, 0);
    expect_out(64'h7FFF, 8'h02, "R4 neg minus pos");
    drive(64'h8000, 64'h8001, 2'd1, 1, 1, 0);
    expect_out(64'hFFFF, 8'h00, "R4 same sign subtract");
    drive(64'h0, 64'h1, 2'd2, 1, 0, 0);
    expect_out(64'h00000000_FFFFFFFF, 8'h08, "R5 unsigned borrow R6 wrap");
    drive(64'h7F, 64'h01, 2'd0, 0, 1, 1);
    expect_out(64'h7F, 8'h01, "R7 positive clamp");
    drive(64'h80, 64'hFF, 2'd0, 0, 1, 1);
    expect_out(64'h80, 8'h01, "R7 negative clamp");
    drive(64'h8000_0000_0000_0000, 64'h1, 2'd3, 1, 1, 1);
    expect_out(64'h8000_0000_0000_0000, 8'h80, "R7 full width clamp");
    drive(64'hFFFF, 64'h2, 2'd1, 0, 0, 1);
    expect_out(64'hFFFF, 8'h02, "R8 unsigned add clamp");
    drive(64'h1, 64'h2, 2'd1, 1, 0, 1);
    expect_out(64'h0, 8'h02, "R8 unsigned subtract clamp");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 0, 0, 0);
    expect_out(64'h0, 8'h80, "R9 full width flag");
    drive(64'h01FF_0000_0000_0000, 64'h0001_0000_0000_0000, 2'd0, 0, 0, 0);
    expect_out(64'h0100_0000_0000_0000, 8'h40, "R10 neighbour untouched");
    drive(64'h01FF_0000_0000_0000, 64'h0001_0000_0000_0000, 2'd0, 0, 0, 1);
    expect_out(64'h01FF_0000_0000_0000, 8'h40, "R10 clamp stays in lane");

    for (int n = 0; n < 4000; n++) begin
      logic [63:0] a, b;
      for (int j = 0; j < 8; j++) begin
        a[j*8 +: 8] = edge_byte();
        b[j*8 +: 8] = edge_byte();
      end
      drive(a, b, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    cmp_on = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule